// File: doc/BRIEF.md
# Pad Ownership Handover Sequencer

This block decides who drives the pads of a serial audio link: an always-on glue domain or the link master. It receives two one-cycle commands. The first command resets the pads to a safe idle, moves control to the master and then programs the clock-control fields. The second command returns control to the glue domain. Every change to a control bit is a separate step. After each step the block waits a fixed settle interval before it starts the next one. The settle interval is given in nanoseconds and converted to clock cycles from the clock frequency parameter.

The block is built around one state machine. `ST_IDLE` accepts commands. The init command goes to `ST_INIT_KEEP`, then through `ST_INIT_WPD`, `ST_INIT_DO` and `ST_INIT_DOE`. It continues without a pause into the handover states `ST_HO_DOE_OFF`, `ST_HO_DO_OFF`, `ST_HO_MIF` and `ST_HO_KEEP_OFF`, and then into `ST_CLK_CFG`. The release command goes through `ST_RET_KEEP` and then `ST_RET_MIF`. Both paths end in `ST_FINISH`, which lasts one cycle and then returns to `ST_IDLE`. In `ST_FINISH` a new command may also be accepted, which starts the next sequence directly.

The block moves from one step state to the next only when the settle timer has expired. It leaves `ST_IDLE` or `ST_FINISH` only when it takes a command. The control bits are updated on the clock edge that enters a step state.

Top module: `pad_handover_seq`

## Requirements
- R1: After reset every pad-control output, every clock-control field, `busy`, `done` and `owner_master` is 0.
- R2: The init command applies four steps in this order. Each step is applied on the edge that samples the command or on the edge that enters the step. (1) All pad bits are cleared and the keeper is set. (2) The wake pull-down disable is set. (3) The data output is set. (4) The data output enable is set.
- R3: Directly after init, the handover applies four more steps in this order. (1) The data output enable is cleared. (2) The data output is cleared. (3) The master select is set. (4) The keeper and the clock output enable are cleared on the same edge.
- R4: After the handover, one further step writes the clock-control fields: `idle_lvl` becomes IDLE_VAL (1 by default), and `queue_en` and `drive_hi` become 1.
- R5: The release command applies two steps in this order. (1) The keeper and the clock output enable are set together. (2) The master select is cleared.
- R6: Each step holds its values for exactly SETTLE_CYCLES cycles, where SETTLE_CYCLES = max(1, CLK_HZ·SETTLE_NS/10^9), before the next step or the done cycle.
- R7: A command seen while `busy` is high has no effect on the outputs or on the step timing.
- R8: If both commands are high in a cycle where the block can accept a command, the init command wins.
- R9: `busy` is high from the cycle after a command is accepted until the last settle interval ends. `done` is then high for exactly one cycle, with `busy` low.
- R10: A command that arrives in the `done` cycle is accepted and starts its sequence on the next edge.
- R11: `owner_master` is 1 from the master-select step of a handover until the master select is cleared by a release.
- R12: The release sequence leaves the clock-control fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_init | input | 1 | Pulse: initialise the pads and hand them to the master |
| cmd_release | input | 1 | Pulse: return the pads to the glue domain |
| keeper_en | output | 1 | Bus keeper enable |
| clk_oe | output | 1 | Clock output enable |
| dout | output | 1 | Data output level |
| dout_oe | output | 1 | Data output enable |
| wake_pd_dis | output | 1 | Wake pull-down disable |
| master_sel | output | 1 | Pad mux select: 1 = master drives |
| idle_lvl | output | IDLE_W | Data-output idle-state field |
| queue_en | output | 1 | Clock-control queue enable |
| drive_hi | output | 1 | Data-output drive-strength select |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| owner_master | output | 1 | Current owner: 1 = master, 0 = glue |

## Verification
Two functions can fall in the same cycle. One is the end of a sequence, the `done` cycle. The other is the acceptance of a new command. The bench raises both commands together exactly in a `done` cycle, and then raises a release in the next `done` cycle. It judges the result by whether the first step of the expected sequence appears one edge later, with the init sequence winning the tie. Separately, it raises both commands in the middle of a running step and checks that every later step keeps its values and its boundaries.

// File: rtl/pad_handover_pkg.sv
package pad_handover_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT_KEEP,
        ST_INIT_WPD,
        ST_INIT_DO,
        ST_INIT_DOE,
        ST_HO_DOE_OFF,
        ST_HO_DO_OFF,
        ST_HO_MIF,
        ST_HO_KEEP_OFF,
        ST_CLK_CFG,
        ST_RET_KEEP,
        ST_RET_MIF,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic keeper;
        logic clk_oe;
        logic dout;
        logic dout_oe;
        logic wpd_dis;
        logic msel;
    } pad_ctrl_t;

    // A step state is any state that holds for a settle interval.
    function automatic logic is_step(input seq_state_e s);
        return (s != ST_IDLE) && (s != ST_FINISH);
    endfunction

endpackage

// File: rtl/phs_settle_timer.sv
module phs_settle_timer #(
    parameter int CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int W = (CNT > 1) ? $clog2(CNT) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(CNT - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/phs_step_apply.sv
module phs_step_apply
    import pad_handover_pkg::*;
#(
    parameter int IDLE_W   = 2,
    parameter int IDLE_VAL = 1
) (
    input  seq_state_e        step,
    input  pad_ctrl_t         pad_cur,
    input  logic [IDLE_W-1:0] idle_cur,
    input  logic              q_cur,
    input  logic              drv_cur,
    output pad_ctrl_t         pad_new,
    output logic [IDLE_W-1:0] idle_new,
    output logic              q_new,
    output logic              drv_new
);
    always_comb begin
        pad_new  = pad_cur;
        idle_new = idle_cur;
        q_new    = q_cur;
        drv_new  = drv_cur;
        unique case (step)
            ST_INIT_KEEP: begin
                pad_new        = '0;
                pad_new.keeper = 1'b1;
            end
            ST_INIT_WPD:    pad_new.wpd_dis = 1'b1;
            ST_INIT_DO:     pad_new.dout    = 1'b1;
            ST_INIT_DOE:    pad_new.dout_oe = 1'b1;
            ST_HO_DOE_OFF:  pad_new.dout_oe = 1'b0;
            ST_HO_DO_OFF:   pad_new.dout    = 1'b0;
            ST_HO_MIF:      pad_new.msel    = 1'b1;
            ST_HO_KEEP_OFF: begin
                pad_new.keeper = 1'b0;
                pad_new.clk_oe = 1'b0;
            end
            ST_CLK_CFG: begin
                idle_new = IDLE_W'(IDLE_VAL);
                q_new    = 1'b1;
                drv_new  = 1'b1;
            end
            ST_RET_KEEP: begin
                pad_new.keeper = 1'b1;
                pad_new.clk_oe = 1'b1;
            end
            ST_RET_MIF:     pad_new.msel = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/pad_handover_seq.sv
module pad_handover_seq
    import pad_handover_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SETTLE_NS = 12_000,
    parameter int IDLE_W    = 2,
    parameter int IDLE_VAL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_init,
    input  logic              cmd_release,
    output logic              keeper_en,
    output logic              clk_oe,
    output logic              dout,
    output logic              dout_oe,
    output logic              wake_pd_dis,
    output logic              master_sel,
    output logic [IDLE_W-1:0] idle_lvl,
    output logic              queue_en,
    output logic              drive_hi,
    output logic              busy,
    output logic              done,
    output logic              owner_master
);
    localparam longint RAW_CYCLES    = (longint'(CLK_HZ) * longint'(SETTLE_NS)) / 64'd1_000_000_000;
    localparam int     SETTLE_CYCLES = (RAW_CYCLES < 1) ? 1 : int'(RAW_CYCLES);

    seq_state_e state_q, state_d;
    logic       expired;
    logic       enter_step;

    pad_ctrl_t         pad_q, pad_d;
    logic [IDLE_W-1:0] idle_q, idle_d;
    logic              q_q, q_d, drv_q, drv_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (cmd_init)         state_d = ST_INIT_KEEP;
                else if (cmd_release) state_d = ST_RET_KEEP;
                else                  state_d = ST_IDLE;
            end
            ST_INIT_KEEP:   if (expired) state_d = ST_INIT_WPD;
            ST_INIT_WPD:    if (expired) state_d = ST_INIT_DO;
            ST_INIT_DO:     if (expired) state_d = ST_INIT_DOE;
            ST_INIT_DOE:    if (expired) state_d = ST_HO_DOE_OFF;
            ST_HO_DOE_OFF:  if (expired) state_d = ST_HO_DO_OFF;
            ST_HO_DO_OFF:   if (expired) state_d = ST_HO_MIF;
            ST_HO_MIF:      if (expired) state_d = ST_HO_KEEP_OFF;
            ST_HO_KEEP_OFF: if (expired) state_d = ST_CLK_CFG;
            ST_CLK_CFG:     if (expired) state_d = ST_FINISH;
            ST_RET_KEEP:    if (expired) state_d = ST_RET_MIF;
            ST_RET_MIF:     if (expired) state_d = ST_FINISH;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign enter_step = (state_d != state_q) && is_step(state_d);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    phs_settle_timer #(.CNT(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_step),
        .expired (expired)
    );

    phs_step_apply #(.IDLE_W(IDLE_W), .IDLE_VAL(IDLE_VAL)) u_apply (
        .step     (state_d),
        .pad_cur  (pad_q),
        .idle_cur (idle_q),
        .q_cur    (q_q),
        .drv_cur  (drv_q),
        .pad_new  (pad_d),
        .idle_new (idle_d),
        .q_new    (q_d),
        .drv_new  (drv_d)
    );

    // Output registers: written only on entry to a step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_q  <= '0;
            idle_q <= '0;
            q_q    <= 1'b0;
            drv_q  <= 1'b0;
        end else if (enter_step) begin
            pad_q  <= pad_d;
            idle_q <= idle_d;
            q_q    <= q_d;
            drv_q  <= drv_d;
        end
    end

    assign keeper_en    = pad_q.keeper;
    assign clk_oe       = pad_q.clk_oe;
    assign dout         = pad_q.dout;
    assign dout_oe      = pad_q.dout_oe;
    assign wake_pd_dis  = pad_q.wpd_dis;
    assign master_sel   = pad_q.msel;
    assign owner_master = pad_q.msel;
    assign idle_lvl     = idle_q;
    assign queue_en     = q_q;
    assign drive_hi     = drv_q;
    assign busy         = is_step(state_q);
    assign done         = (state_q == ST_FINISH);

endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
    parameter int SETTLE = 1
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic keeper_en,
    input logic clk_oe,
    input logic dout,
    input logic dout_oe,
    input logic wake_pd_dis,
    input logic master_sel
);
    logic [5:0] pad, pad_prev_q;
    logic       chg, seen_q;
    int         gap_q;

    assign pad = {keeper_en, clk_oe, dout, dout_oe, wake_pd_dis, master_sel};
    assign chg = (pad != pad_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_prev_q <= '0;
            seen_q     <= 1'b0;
            gap_q      <= 0;
        end else begin
            pad_prev_q <= pad;
            if (chg) begin
                seen_q <= 1'b1;
                gap_q  <= 0;
            end else if (gap_q < SETTLE + 2) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r3_select_after_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_sel) |-> (!dout_oe && !dout && keeper_en));

    a_r5_keeper_before_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master_sel) |-> (keeper_en && clk_oe));

    a_r2_small_step: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> ($countones(pad ^ pad_prev_q) <= 5));

    a_r6_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && seen_q) |-> (gap_q >= SETTLE - 1));

endmodule

bind pad_handover_seq phs_checker #(.SETTLE(SETTLE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .keeper_en   (keeper_en),
    .clk_oe      (clk_oe),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .wake_pd_dis (wake_pd_dis),
    .master_sel  (master_sel)
);

// File: tb/sim_pad_handover_seq.sv
`timescale 1ns/1ps
module sim_pad_handover_seq;
    localparam int S = 4;   // 100 MHz, 40 ns settle

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_init = 1'b0;
    logic       cmd_release = 1'b0;
    logic       keeper_en, clk_oe, dout, dout_oe, wake_pd_dis, master_sel;
    logic [1:0] idle_lvl;
    logic       queue_en, drive_hi, busy, done, owner_master;

    int total = 0;
    int failed = 0;

    always #5 clk = ~clk;

    pad_handover_seq #(
        .CLK_HZ(100_000_000), .SETTLE_NS(40), .IDLE_W(2), .IDLE_VAL(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_init(cmd_init), .cmd_release(cmd_release),
        .keeper_en(keeper_en), .clk_oe(clk_oe), .dout(dout), .dout_oe(dout_oe),
        .wake_pd_dis(wake_pd_dis), .master_sel(master_sel), .idle_lvl(idle_lvl),
        .queue_en(queue_en), .drive_hi(drive_hi), .busy(busy), .done(done),
        .owner_master(owner_master)
    );

    // {keeper, clk_oe, dout, dout_oe, wake_pd_dis, master_sel, idle_lvl[1:0], queue_en, drive_hi}
    // Index 0-3 init (R2), 4-7 handover (R3), 8 clock config (R4), 9-10 release (R5).
    localparam logic [9:0] VEC [0:10] = '{
        10'b100000_0000,
        10'b100010_0000,
        10'b101010_0000,
        10'b101110_0000,
        10'b101010_0000,
        10'b100010_0000,
        10'b100011_0000,
        10'b000011_0000,
        10'b000011_0111,
        10'b110011_0111,
        10'b110010_0111
    };

    function automatic logic [9:0] outs();
        return {keeper_en, clk_oe, dout, dout_oe, wake_pd_dis, master_sel,
                idle_lvl, queue_en, drive_hi};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string step_tag(input int idx);
        if (idx < 4)  return "R2";
        if (idx < 8)  return "R3";
        if (idx == 8) return "R4";
        return "R5";
    endfunction

    // Called at a negedge with no command pending; drives the command pulse,
    // walks the vector table, and returns at the negedge of the done cycle.
    task automatic run_seq(input bit d_init, input bit d_rel, input bit exp_init,
                           input int intr_n);
        int first = exp_init ? 0 : 9;
        int nst   = exp_init ? 9 : 2;
        cmd_init    = d_init;
        cmd_release = d_rel;
        for (int n = 0; n <= nst * S; n++) begin
            @(negedge clk);
            cmd_init    = 1'b0;
            cmd_release = 1'b0;
            if (n == nst * S) begin
                check("R9 done high", 32'(done), 32'd1);
                check("R9 busy low at done", 32'(busy), 32'd0);
            end else begin
                int k = n / S;
                int r = n % S;
                int idx = first + k;
                if (n == intr_n) begin
                    cmd_init    = 1'b1;   // R7: must be ignored while busy
                    cmd_release = 1'b1;
                end
                if (r == 0 || r == S - 1) begin
                    logic [9:0] m = (idx < 8) ? 10'b111111_0000 : 10'b111111_1111;
                    check({step_tag(idx), " R6 R7 step value"},
                          32'(outs() & m), 32'(VEC[idx] & m));
                    check("R9 busy high", 32'(busy), 32'd1);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 32'(outs()), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 32'(outs()), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 owner", 32'(owner_master), 32'd0);

        // Table walk: full init + handover + clock config
        run_seq(1'b1, 1'b0, 1'b1, -1);
        @(negedge clk);
        check("R9 done falls", 32'(done), 32'd0);
        check("R11 owner master", 32'(owner_master), 32'd1);
        check("R4 idle level", 32'(idle_lvl), 32'd1);

        // Release with both commands injected mid-step (R7)
        run_seq(1'b0, 1'b1, 1'b0, S + 1);
        check("R12 cfg kept", 32'({idle_lvl, queue_en, drive_hi}), 32'h7);
        check("R11 owner glue", 32'(owner_master), 32'd0);

        // R10 + R8: both commands in the done cycle -> init wins
        run_seq(1'b1, 1'b1, 1'b1, 2 * S + 2);
        // R10: release in the done cycle
        run_seq(1'b0, 1'b1, 1'b0, -1);
        @(negedge clk);
        check("R9 done falls after release", 32'(done), 32'd0);
        check("R10 idle after release", 32'(busy), 32'd0);

        // R8 from idle
        run_seq(1'b1, 1'b1, 1'b1, -1);
        check("R8 owner after init", 32'(owner_master), 32'd1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule